// File: doc/BRIEF.md
# Dual-Mode Loop-Back Link Channel

This block is the full-duplex link between two neighbouring routers, called side A and side B, in a deflection-routed mesh. Each router presents one outgoing flit per cycle, with a valid flag and a flag that says whether the router sent that flit in a productive direction. The link holds one flit register toward each router. In front of those registers sits a two-by-two crossover that is set again on every cycle.

When either end offers a valid productive flit, the crossover is in exchange mode. The flits then cross the link as on an ordinary channel. When neither end offers one, the link is in loop-back mode: each flit is written into the register that feeds its own router. A deflected flit therefore waits in place for one cycle and does not take a non-productive hop. The mode is decided by combinational logic from the current inputs only. Two counters record how many cycles the link spent in each mode while it carried traffic, so that the behaviour can be observed.

Top module: `dual_mode_link`

## Requirements
- R1: `xchg_mode` is 1 in the same cycle exactly when (`a_vld` and `a_prod`) or (`b_vld` and `b_prod`). Otherwise it is 0.
- R2: In a cycle with `xchg_mode`=1, the next clock edge loads `to_b_flit`/`to_b_vld` from `a_flit`/`a_vld`, and loads `to_a_flit`/`to_a_vld` from `b_flit`/`b_vld`.
- R3: In a cycle with `xchg_mode`=0, the next clock edge loads `to_a_flit`/`to_a_vld` from `a_flit`/`a_vld`, and loads `to_b_flit`/`to_b_vld` from `b_flit`/`b_vld`.
- R4: A productive flag on a side whose valid is 0 has no effect. With `a_vld`=0 and `a_prod`=1 against a valid deflected flit from B, that flit returns on `to_b`.
- R5: Each valid bit moves together with its flit. If both inputs are invalid, both `to_a_vld` and `to_b_vld` are 0 after the edge.
- R6: A valid productive flit is never looped back. After the edge it appears on the register that feeds the opposite router.
- R7: While the synchronous reset `rst` is high at an edge, both output valid bits clear and both counters become 0.
- R8: `loop_cnt` increments by one for each clock in loop-back mode in which at least one input is valid. It wraps at 2^CNT_W.
- R9: `xchg_cnt` increments by one for each clock in exchange mode.
- R10: When both inputs are invalid, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both link registers |
| rst | input | 1 | Synchronous reset, active high |
| a_flit | input | FLIT_W | Outgoing flit of router A |
| a_vld | input | 1 | A flit present |
| a_prod | input | 1 | A flit routed productively |
| b_flit | input | FLIT_W | Outgoing flit of router B |
| b_vld | input | 1 | B flit present |
| b_prod | input | 1 | B flit routed productively |
| to_a_flit | output | FLIT_W | Register feeding router A's input |
| to_a_vld | output | 1 | Valid of `to_a_flit` |
| to_b_flit | output | FLIT_W | Register feeding router B's input |
| to_b_vld | output | 1 | Valid of `to_b_flit` |
| xchg_mode | output | 1 | Current-cycle mode: 1 exchange, 0 loop-back |
| loop_cnt | output | CNT_W | Busy loop-back cycle count |
| xchg_cnt | output | CNT_W | Exchange cycle count |

## Verification
The assertions check four things on every cycle: that valid bits follow the chosen crossover setting, that a productive flit always lands on the far side with its data intact, that reset empties the link, and that each counter moves only in its own mode and stays still when the link is idle. Some behaviour can only be shown by the bench's scenarios. These are the full sweep of all sixteen combinations of valid and productive flags with distinct payloads, the specific case of a productive flag raised on an empty side, and counter totals accumulated over long mixed sequences and then cleared by a reset in mid-traffic.

// File: rtl/dual_mode_link.sv
module dual_mode_link #(
  parameter int FLIT_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLIT_W-1:0] a_flit,
  input  logic              a_vld,
  input  logic              a_prod,
  input  logic [FLIT_W-1:0] b_flit,
  input  logic              b_vld,
  input  logic              b_prod,
  output logic [FLIT_W-1:0] to_a_flit,
  output logic              to_a_vld,
  output logic [FLIT_W-1:0] to_b_flit,
  output logic              to_b_vld,
  output logic              xchg_mode,
  output logic [CNT_W-1:0]  loop_cnt,
  output logic [CNT_W-1:0]  xchg_cnt
);

  logic a_go, b_go, busy;

  assign a_go      = a_vld & a_prod;
  assign b_go      = b_vld & b_prod;
  assign xchg_mode = a_go | b_go;
  assign busy      = a_vld | b_vld;

  always_ff @(posedge clk) begin
    to_b_flit <= xchg_mode ? a_flit : b_flit;
    to_a_flit <= xchg_mode ? b_flit : a_flit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_a_vld <= 1'b0;
      to_b_vld <= 1'b0;
      loop_cnt <= '0;
      xchg_cnt <= '0;
    end else begin
      to_b_vld <= xchg_mode ? a_vld : b_vld;
      to_a_vld <= xchg_mode ? b_vld : a_vld;
      if (xchg_mode)
        xchg_cnt <= xchg_cnt + 1'b1;
      else if (busy)
        loop_cnt <= loop_cnt + 1'b1;
    end
  end

  assert_reset_empty_R7: assert property (@(posedge clk)
    rst |=> (!to_a_vld && !to_b_vld && loop_cnt == '0 && xchg_cnt == '0));

  assert_prod_a_forward_R6: assert property (@(posedge clk) disable iff (rst)
    (a_vld && a_prod) |=> (to_b_vld && to_b_flit == $past(a_flit)));

  assert_prod_b_forward_R6: assert property (@(posedge clk) disable iff (rst)
    (b_vld && b_prod) |=> (to_a_vld && to_a_flit == $past(b_flit)));

  assert_loop_valids_R3: assert property (@(posedge clk) disable iff (rst)
    (!(a_vld && a_prod) && !(b_vld && b_prod)) |=>
      (to_a_vld == $past(a_vld) && to_b_vld == $past(b_vld)));

  assert_xchg_valids_R2: assert property (@(posedge clk) disable iff (rst)
    xchg_mode |=> (to_b_vld == $past(a_vld) && to_a_vld == $past(b_vld)));

  assert_idle_counts_R10: assert property (@(posedge clk) disable iff (rst)
    (!a_vld && !b_vld) |=> ($stable(loop_cnt) && $stable(xchg_cnt)));

  assert_loop_count_R8: assert property (@(posedge clk) disable iff (rst)
    (!xchg_mode && (a_vld || b_vld)) |=>
      (loop_cnt == CNT_W'($past(loop_cnt) + 1) && $stable(xchg_cnt)));

  assert_xchg_count_R9: assert property (@(posedge clk) disable iff (rst)
    xchg_mode |=> (xchg_cnt == CNT_W'($past(xchg_cnt) + 1) && $stable(loop_cnt)));

endmodule

// File: tb/sim_dual_mode_link.sv
module sim_dual_mode_link;
  localparam int FW = 32;
  localparam int CW = 16;
  localparam logic [3:0] VEC [16] = '{
    4'b1010, 4'b0000, 4'b1111, 4'b1000, 4'b0010, 4'b1100, 4'b0011, 4'b1110,
    4'b0101, 4'b1011, 4'b0100, 4'b0001, 4'b1001, 4'b0110, 4'b1101, 4'b0111
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [FW-1:0] a_flit = '0, b_flit = '0;
  logic a_vld = 1'b0, a_prod = 1'b0, b_vld = 1'b0, b_prod = 1'b0;
  logic [FW-1:0] to_a_flit, to_b_flit;
  logic to_a_vld, to_b_vld, xchg_mode;
  logic [CW-1:0] loop_cnt, xchg_cnt;
  int n_chk = 0, n_bad = 0;
  int e_loop = 0, e_xchg = 0;

  always #4 clk = ~clk;

  dual_mode_link #(.FLIT_W(FW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst),
    .a_flit(a_flit), .a_vld(a_vld), .a_prod(a_prod),
    .b_flit(b_flit), .b_vld(b_vld), .b_prod(b_prod),
    .to_a_flit(to_a_flit), .to_a_vld(to_a_vld),
    .to_b_flit(to_b_flit), .to_b_vld(to_b_vld),
    .xchg_mode(xchg_mode), .loop_cnt(loop_cnt), .xchg_cnt(xchg_cnt));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic av, input logic ap, input logic bv, input logic bp,
                       input logic [FW-1:0] af, input logic [FW-1:0] bf);
    logic xm;
    xm = (av & ap) | (bv & bp);
    a_vld = av; a_prod = ap; b_vld = bv; b_prod = bp; a_flit = af; b_flit = bf;
    #1;
    chk("R1 mode", {63'd0, xchg_mode}, {63'd0, xm});
    if (xm) e_xchg++;
    else if (av | bv) e_loop++;
    @(posedge clk);
    @(negedge clk);
    if (xm) begin
      chk("R2 to_b_vld", {63'd0, to_b_vld}, {63'd0, av});
      chk("R2 to_a_vld", {63'd0, to_a_vld}, {63'd0, bv});
      if (av) chk("R2 to_b_flit", {32'd0, to_b_flit}, {32'd0, af});
      if (bv) chk("R2 to_a_flit", {32'd0, to_a_flit}, {32'd0, bf});
    end else begin
      chk("R3 to_a_vld", {63'd0, to_a_vld}, {63'd0, av});
      chk("R3 to_b_vld", {63'd0, to_b_vld}, {63'd0, bv});
      if (av) chk("R3 to_a_flit", {32'd0, to_a_flit}, {32'd0, af});
      if (bv) chk("R3 to_b_flit", {32'd0, to_b_flit}, {32'd0, bf});
    end
    if (!av && !bv) chk("R5 empty valids", {62'd0, to_a_vld, to_b_vld}, 64'd0);
    chk(xm ? "R9 xchg_cnt" : "R10 xchg_cnt", {48'd0, xchg_cnt}, 64'(CW'(e_xchg)));
    chk((av | bv) ? "R8 loop_cnt" : "R10 loop_cnt", {48'd0, loop_cnt}, 64'(CW'(e_loop)));
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R7 reset valids", {62'd0, to_a_vld, to_b_vld}, 64'd0);
    chk("R7 reset counters", {32'd0, loop_cnt, xchg_cnt}, 64'd0);
    rst = 1'b0;

    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 16; i++) begin
        apply(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
              32'hA500_0000 ^ 32'(pass << 12) ^ 32'(i * 32'h0101),
              32'h5B00_0000 ^ 32'(pass << 16) ^ 32'(i * 32'h1003));
      end
    end

    // R4: productive flag on an empty side is ignored
    apply(1'b0, 1'b1, 1'b1, 1'b0, 32'hDEAD_0001, 32'hC0DE_0004);
    chk("R4 b flit returns", {31'd0, to_b_vld, to_b_flit}, {31'd0, 1'b1, 32'hC0DE_0004});
    chk("R4 nothing to a", {63'd0, to_a_vld}, 64'd0);

    // R6: productive flit crosses even against a deflected one
    apply(1'b1, 1'b1, 1'b1, 1'b0, 32'h1111_2222, 32'h3333_4444);
    chk("R6 a crosses", {31'd0, to_b_vld, to_b_flit}, {31'd0, 1'b1, 32'h1111_2222});
    apply(1'b1, 1'b0, 1'b1, 1'b1, 32'h5555_6666, 32'h7777_8888);
    chk("R6 b crosses", {31'd0, to_a_vld, to_a_flit}, {31'd0, 1'b1, 32'h7777_8888});

    // R10: long idle run leaves counters alone
    for (int k = 0; k < 5; k++) apply(1'b0, 1'b1, 1'b0, 1'b1, 32'(k), 32'(k + 9));

    // R7: reset in mid-traffic
    a_vld = 1'b1; a_prod = 1'b0; b_vld = 1'b1; b_prod = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 mid reset valids", {62'd0, to_a_vld, to_b_vld}, 64'd0);
    chk("R7 mid reset counters", {32'd0, loop_cnt, xchg_cnt}, 64'd0);
    rst = 1'b0;
    e_loop = 0; e_xchg = 0;
    apply(1'b1, 1'b0, 1'b0, 1'b0, 32'hFACE_0001, 32'h0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 32'hFACE_0002, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule